// File: doc/BRIEF.md
# Switchable Per-Channel Input Settling Filter

This block conditions sixteen raw digital inputs before they reach the rest of a chip. Every input first passes through a two-flop synchronizer. Each channel can then take one of two paths. On the direct path the synchronized level goes straight to the output. On the settling path a new level reaches the output only after it has held steady for a programmable number of clock cycles. The default setting gives about 5 ms at 50 MHz. This settling path suppresses noise spikes and turns a rectified AC signal into a steady level.

Two controls decide which path a channel uses. A global flag is set by an enable pulse and cleared by a disable pulse, and it puts all sixteen channels on the settling path. An eight-bit mask picks the settling path for channels 0-7 one channel at a time, but it only counts while the global flag is clear. Channels 8-15 have no mask bit. A readback byte reports the effective enable of channels 0-7. All pins are plain control and status signals. There is no streamed data, so there is no valid/ready handshake and no back-pressure.

Top module: `chan_settle_filter`

## Requirements
- R1: After reset the global flag and the mask are 0, `lvl_out` reads all zeros and `mask_rd` reads 0x00.
- R2: A channel on the direct path shows a change on `raw_in` at `lvl_out` after exactly three rising clock edges: two synchronizer stages plus the output register.
- R3: A cycle with `glb_dis` high clears the global flag. A cycle with `glb_en` high and `glb_dis` low sets it. When both are high in the same cycle, disable wins.
- R4: While the global flag is set, every channel 0-15 uses the settling path, whatever the mask holds.
- R5: A cycle with `mask_we` high stores `mask_wdata`. Bit i selects channel i (0-7), and a 1 puts that channel on the settling path.
- R6: The mask is stored even while the global flag is set. It takes effect once the flag clears, and setting or clearing the flag never alters it.
- R7: While the global flag is clear, channels 8-15 always use the direct path.
- R8: On the settling path, once the synchronized input differs from `lvl_out`, the output takes the new level after FILT_CYCLES consecutive differing cycles. That is FILT_CYCLES+2 edges after `raw_in` changes.
- R9: On the settling path, a pulse on `raw_in` shorter than FILT_CYCLES cycles never reaches `lvl_out`. When the input falls back, the count restarts.
- R10: `mask_rd` bit i is the effective settling enable of channel i (0-7). It reads 0xFF while the global flag is set and equals the stored mask otherwise.
- R11: When a channel's settling enable turns off, its output takes the current synchronized level on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_in | input | 16 | Unsynchronized raw channel levels |
| glb_en | input | 1 | One-cycle pulse that sets the global flag |
| glb_dis | input | 1 | One-cycle pulse that clears the global flag |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | Mask value for channels 0-7 |
| lvl_out | output | 16 | Conditioned channel levels |
| mask_rd | output | 8 | Effective settling enables of channels 0-7 |

## Verification
The bench builds the block with FILT_CYCLES set to 16 and keeps sixteen channels with an eight-bit mask. A short settling period makes it practical to check the exact edge on which a held level passes, one cycle either side of the boundary. It also lets the bench check glitches of FILT_CYCLES-1 cycles that must be rejected, and hand-offs between the flag and the mask, in a run of a few hundred cycles. The high channels take the same paths as in the full-size build, so the split between masked and unmasked channels is covered unchanged.

// File: rtl/cond_pkg.sv
package cond_pkg;
  localparam int unsigned DEF_FILT_CYCLES = 250000;
  localparam int unsigned DEF_NUM_CH      = 16;
  localparam int unsigned DEF_MASK_CH     = 8;

  typedef enum logic [1:0] {
    GCMD_HOLD = 2'd0,
    GCMD_SET  = 2'd1,
    GCMD_CLR  = 2'd2
  } glb_cmd_e;
endpackage

// File: rtl/cond_sync2.sv
module cond_sync2 #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/cond_enable.sv
module cond_enable
  import cond_pkg::*;
#(
  parameter int unsigned NUM_CH  = DEF_NUM_CH,
  parameter int unsigned MASK_CH = DEF_MASK_CH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glb_en,
  input  logic               glb_dis,
  input  logic               mask_we,
  input  logic [MASK_CH-1:0] mask_wdata,
  output logic [NUM_CH-1:0]  ch_en,
  output logic [MASK_CH-1:0] mask_rd
);
  logic               glb_flag;
  logic [MASK_CH-1:0] mask_q;
  glb_cmd_e           cmd;

  always_comb begin
    if (glb_dis)     cmd = GCMD_CLR;
    else if (glb_en) cmd = GCMD_SET;
    else             cmd = GCMD_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_flag <= 1'b0;
      mask_q   <= '0;
    end else begin
      case (cmd)
        GCMD_SET: glb_flag <= 1'b1;
        GCMD_CLR: glb_flag <= 1'b0;
        default:  glb_flag <= glb_flag;
      endcase
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_en
    if (i < MASK_CH) begin : g_masked
      assign ch_en[i] = glb_flag | mask_q[i];
    end else begin : g_global_only
      assign ch_en[i] = glb_flag;
    end
  end

  assign mask_rd = ch_en[MASK_CH-1:0];

  a_r3_dis_wins: assert property (@(posedge clk) disable iff (!rst_n)
    glb_dis |=> (ch_en[NUM_CH-1] == 1'b0));
  a_r3_en_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && !glb_dis) |=> (&mask_rd));
  a_r5_mask_store: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(mask_wdata)));
  a_r6_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/cond_settle.sv
module cond_settle #(
  parameter int unsigned FILT_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic s_in,
  output logic lvl
);
  localparam int unsigned CNT_W = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= 1'b0;
      cnt <= '0;
    end else if (!en) begin
      lvl <= s_in;
      cnt <= '0;
    end else if (s_in == lvl) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      lvl <= s_in;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r11_direct_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (lvl == $past(s_in)));
  a_r9_steady_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (s_in == lvl)) |=> $stable(lvl));
  a_r8_no_early_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (s_in != lvl) && (cnt != LAST)) |=> $stable(lvl));
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/chan_settle_filter.sv
module chan_settle_filter
  import cond_pkg::*;
#(
  parameter int unsigned NUM_CH      = DEF_NUM_CH,
  parameter int unsigned MASK_CH     = DEF_MASK_CH,
  parameter int unsigned FILT_CYCLES = DEF_FILT_CYCLES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CH-1:0]  raw_in,
  input  logic               glb_en,
  input  logic               glb_dis,
  input  logic               mask_we,
  input  logic [MASK_CH-1:0] mask_wdata,
  output logic [NUM_CH-1:0]  lvl_out,
  output logic [MASK_CH-1:0] mask_rd
);
  logic [NUM_CH-1:0] synced;
  logic [NUM_CH-1:0] ch_en;

  cond_sync2 #(.W(NUM_CH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (synced)
  );

  cond_enable #(.NUM_CH(NUM_CH), .MASK_CH(MASK_CH)) u_enable (
    .clk        (clk),
    .rst_n      (rst_n),
    .glb_en     (glb_en),
    .glb_dis    (glb_dis),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .ch_en      (ch_en),
    .mask_rd    (mask_rd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cond_settle #(.FILT_CYCLES(FILT_CYCLES)) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ch_en[c]),
      .s_in  (synced[c]),
      .lvl   (lvl_out[c])
    );
  end

  a_r7_high_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_rd != {MASK_CH{1'b1}}) |=> (lvl_out[NUM_CH-1] == $past(synced[NUM_CH-1])));
endmodule

// File: tb/tb_chan_settle_filter.sv
module tb_chan_settle_filter;
  localparam int NCH = 16;
  localparam int NMK = 8;
  localparam int N   = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  raw_in = '0;
  logic            glb_en = 1'b0, glb_dis = 1'b0, mask_we = 1'b0;
  logic [NMK-1:0]  mask_wdata = '0;
  logic [NCH-1:0]  lvl_out;
  logic [NMK-1:0]  mask_rd;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  chan_settle_filter #(.NUM_CH(NCH), .MASK_CH(NMK), .FILT_CYCLES(N)) dut (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .glb_en(glb_en), .glb_dis(glb_dis),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .lvl_out(lvl_out), .mask_rd(mask_rd)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  int m_p1[NCH], m_p2[NCH], m_out[NCH], m_held[NCH];
  bit m_glb;
  int m_mask[NMK];

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_p1[k]) begin m_p1[k] = 0; m_p2[k] = 0; m_out[k] = 0; m_held[k] = 0; end
      foreach (m_mask[k]) m_mask[k] = 0;
      m_glb = 0;
    end else begin
      for (int k = 0; k < NCH; k++) begin
        bit on;
        on = m_glb || (k < NMK && m_mask[k] != 0);
        if (!on) begin m_out[k] = m_p2[k]; m_held[k] = 0; end
        else if (m_p2[k] == m_out[k]) m_held[k] = 0;
        else begin
          m_held[k] = m_held[k] + 1;
          if (m_held[k] >= N) begin m_out[k] = m_p2[k]; m_held[k] = 0; end
        end
        m_p2[k] = m_p1[k];
        m_p1[k] = int'(raw_in[k]);
      end
      if (glb_dis) m_glb = 0; else if (glb_en) m_glb = 1;
      if (mask_we) for (int k = 0; k < NMK; k++) m_mask[k] = int'(mask_wdata[k]);
    end
  end

  function automatic logic [NCH-1:0] exp_lvl();
    logic [NCH-1:0] v;
    for (int k = 0; k < NCH; k++) v[k] = (m_out[k] != 0);
    return v;
  endfunction

  function automatic logic [NMK-1:0] exp_rd();
    logic [NMK-1:0] v;
    for (int k = 0; k < NMK; k++) v[k] = m_glb || (m_mask[k] != 0);
    return v;
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (lvl_out !== exp_lvl()) begin
        errors++;
        $display("FAIL R2,R8 model lvl_out: actual=%h expected=%h at %0t", lvl_out, exp_lvl(), $time);
      end
      checks++;
      if (mask_rd !== exp_rd()) begin
        errors++;
        $display("FAIL R10 model mask_rd: actual=%h expected=%h at %0t", mask_rd, exp_rd(), $time);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_en();  glb_en = 1;  step(1); glb_en = 0;  endtask
  task automatic pulse_dis(); glb_dis = 1; step(1); glb_dis = 0; endtask
  task automatic wr_mask(input logic [7:0] v);
    mask_wdata = v; mask_we = 1; step(1); mask_we = 0;
  endtask

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    chk("R1 lvl_out", 32'(lvl_out), 32'h0);
    chk("R1 mask_rd", 32'(mask_rd), 32'h0);

    // R2 direct path latency on channel 3
    raw_in[3] = 1;
    step(2);
    chk("R2 after 2 edges", 32'(lvl_out[3]), 32'h0);
    step(1);
    chk("R2 after 3 edges", 32'(lvl_out[3]), 32'h1);

    // R7 high channel direct while global clear
    raw_in[9] = 1;
    step(3);
    chk("R7 ch9 direct", 32'(lvl_out[9]), 32'h1);

    // R5 mask write and readback
    wr_mask(8'h5A);
    chk("R5 mask_rd", 32'(mask_rd), 32'h5A);

    // R8 settling timing on masked channel 1
    raw_in[1] = 1;
    step(N + 1);
    chk("R8 one edge early", 32'(lvl_out[1]), 32'h0);
    step(1);
    chk("R8 at N+2 edges", 32'(lvl_out[1]), 32'h1);

    // R9 short glitch on channel 1 rejected
    raw_in[1] = 0;
    step(N - 1);
    raw_in[1] = 1;
    step(N + 4);
    chk("R9 glitch rejected", 32'(lvl_out[1]), 32'h1);

    // R3/R10 global enable
    pulse_en();
    chk("R3 flag set, R10 reads FF", 32'(mask_rd), 32'hFF);

    // R4 high channel now filtered
    raw_in[15] = 1;
    step(3);
    chk("R4 ch15 held back", 32'(lvl_out[15]), 32'h0);
    step(N - 1);
    chk("R4 ch15 passes", 32'(lvl_out[15]), 32'h1);

    // R6 mask written while global set, kept after clear
    wr_mask(8'h0F);
    chk("R6 still FF while global", 32'(mask_rd), 32'hFF);
    glb_en = 1; glb_dis = 1;
    step(1);
    glb_en = 0; glb_dis = 0;
    chk("R3 disable wins, R6 mask shows", 32'(mask_rd), 32'h0F);

    // R11 channel 15 back to direct path immediately
    raw_in[15] = 0;
    step(3);
    chk("R11 ch15 direct again", 32'(lvl_out[15]), 32'h0);

    // R7 glitch on ch12 passes with global clear
    raw_in[12] = 1;
    step(1);
    raw_in[12] = 0;
    step(2);
    chk("R7 ch12 pulse visible", 32'(lvl_out[12]), 32'h1);
    step(1);
    chk("R7 ch12 pulse gone", 32'(lvl_out[12]), 32'h0);

    // R11 mask off releases a pending level on ch2
    raw_in[2] = 1;
    step(5);
    chk("R8 ch2 pending", 32'(lvl_out[2]), 32'h0);
    wr_mask(8'h00);
    step(1);
    chk("R11 ch2 released", 32'(lvl_out[2]), 32'h1);

    // mixed pattern, model does the checking
    for (int i = 0; i < 40; i++) begin
      raw_in = raw_in ^ 16'(i * 16'h3A5 + 7);
      if (i % 9 == 0) wr_mask(8'(i * 37));
      if (i == 13) pulse_en();
      if (i == 27) pulse_dis();
      step(i % 7 + 1);
    end
    step(2 * N);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule